// File: doc/BRIEF.md
# Exception Entry and Return Controller

This controller sits beside a processor core's banked register file and status register. It performs the hardware side of taking an exception and of leaving one. The request lines are level inputs that the controller samples while it is idle. The two interrupt lines can be masked by bits of the current status word. The remaining requests cannot be masked. When several requests are active, a fixed priority picks one of them.

Once an exception is accepted, the controller spends one cycle driving every write strobe at once:
- the status word is rewritten with the new mode and the new control bits;
- the program counter is loaded with the vector for that exception;
- the link register of the target bank receives the return address;
- the saved status register of the target bank receives the old status word.

A return request instead writes back the saved status word and the resume address. Both writes happen together in one cycle, so the core never sees one of them without the other.

The state machine has three states. `ST_IDLE` samples the requests. It moves to `ST_ENTER` when an exception is accepted, or to `ST_RETURN` when a return is requested and no exception is accepted. Both `ST_ENTER` and `ST_RETURN` go back to `ST_IDLE` unconditionally after one cycle.

Top module: `exc_ctrl`

## Requirements
- R1: While `rst_n` is low, and afterwards while no request is active, all four write strobes stay low.
- R2: When an exception is accepted at a clock edge, the next cycle raises `psr_we`, `pc_we`, `lr_we` and `spsr_we` together for exactly one cycle. In that cycle `bank_mode` gives the target mode:
  - reset and software interrupt select 0x13;
  - undefined instruction selects 0x1B;
  - prefetch abort and data abort select 0x17;
  - IRQ selects 0x12;
  - FIQ selects 0x11.
- R3: In the entry cycle, `lr_wdata` equals the `cur_pc` sampled at acceptance, and `spsr_wdata` equals the `cur_psr` sampled at acceptance.
- R4: In the entry cycle, `psr_wdata` is the old status word with these changes:
  - bits [4:0] are replaced by the target mode;
  - bit 5 (compact-instruction state) is cleared;
  - bit 7 (IRQ disable) is set;
  - bit 6 (FIQ disable) is set for FIQ and reset and left unchanged otherwise;
  - all other bits are unchanged.
- R5: In the entry cycle, `pc_wdata` equals `VEC_BASE` plus the exception's offset: 0x00 reset, 0x04 undefined, 0x08 software interrupt, 0x0C prefetch abort, 0x10 data abort, 0x18 IRQ, 0x1C FIQ.
- R6: Priority, highest first, is reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt. Undefined wins a tie with software interrupt.
- R7: An IRQ request is ignored while `cur_psr` bit 7 is set. An FIQ request is ignored while `cur_psr` bit 6 is set. Reset, the aborts, undefined and software interrupt are never masked.
- R8: A return request accepted at an edge raises `psr_we` and `pc_we` together in the next cycle, carrying `saved_psr` and `resume_pc`, with `lr_we` and `spsr_we` low.
- R9: An exception accepted at the same edge as a return request takes precedence, and the return is dropped.
- R10: Requests are sampled only in `ST_IDLE`. A strobe cycle is always followed by at least one cycle with `psr_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rq_reset | input | 1 | Reset exception request |
| rq_dabort | input | 1 | Data abort request |
| rq_fiq | input | 1 | Fast interrupt request (level) |
| rq_irq | input | 1 | Normal interrupt request (level) |
| rq_pabort | input | 1 | Prefetch abort request |
| rq_undef | input | 1 | Undefined instruction request |
| rq_swi | input | 1 | Software interrupt request |
| rq_return | input | 1 | Exception return request |
| cur_psr | input | PSR_W | Current status word |
| cur_pc | input | PC_W | Return address to save on entry |
| saved_psr | input | PSR_W | Saved status word of the current mode |
| resume_pc | input | PC_W | Address to resume at on return |
| psr_we | output | 1 | Status word write strobe |
| psr_wdata | output | PSR_W | Status word write data |
| pc_we | output | 1 | Program counter write strobe |
| pc_wdata | output | PC_W | Program counter write data |
| lr_we | output | 1 | Link register write strobe (target bank) |
| spsr_we | output | 1 | Saved status write strobe (target bank) |
| bank_mode | output | 5 | Mode selecting the register bank written |
| lr_wdata | output | PC_W | Link register write data |
| spsr_wdata | output | PSR_W | Saved status write data |

## Verification
The assertions check the following on every cycle:
- the four entry strobes move together, and a return never touches the banked registers;
- every entry cycle writes a status word with IRQ disabled, compact state cleared and the mode field matching `bank_mode`;
- an FIQ entry also sets the FIQ mask and loads the FIQ vector;
- IRQ and FIQ entries only follow a cycle in which their mask bit was clear;
- no two strobe cycles are adjacent.

Only the bench scenarios can show:
- that the priority order picks the right winner among mixed requests;
- that every vector and bank mode is correct;
- that the saved return address and status word are the values present at acceptance;
- that a held level interrupt is taken once and then stays masked by the status word the controller wrote.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int MODE_W    = 5;
    localparam int BIT_T     = 5;
    localparam int BIT_F     = 6;
    localparam int BIT_I     = 7;
    localparam int NUM_KINDS = 7;
    localparam int KIND_W    = $clog2(NUM_KINDS);

    localparam logic [MODE_W-1:0] MODE_FAST  = 5'h11;
    localparam logic [MODE_W-1:0] MODE_NORM  = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SUPV  = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABORT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_UNDEF = 5'h1B;

    // Enumeration value is also the priority rank (0 = highest).
    typedef enum logic [KIND_W-1:0] {
        EK_RESET = 3'd0,
        EK_DABT  = 3'd1,
        EK_FIQ   = 3'd2,
        EK_IRQ   = 3'd3,
        EK_PABT  = 3'd4,
        EK_UNDEF = 3'd5,
        EK_SWI   = 3'd6
    } exc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ENTER,
        ST_RETURN
    } ctl_state_e;

    function automatic logic [MODE_W-1:0] kind_mode(input exc_kind_e k);
        unique case (k)
            EK_RESET, EK_SWI: return MODE_SUPV;
            EK_DABT, EK_PABT: return MODE_ABORT;
            EK_FIQ:           return MODE_FAST;
            EK_IRQ:           return MODE_NORM;
            EK_UNDEF:         return MODE_UNDEF;
            default:          return MODE_SUPV;
        endcase
    endfunction

    function automatic logic [7:0] kind_vec_off(input exc_kind_e k);
        unique case (k)
            EK_RESET: return 8'h00;
            EK_UNDEF: return 8'h04;
            EK_SWI:   return 8'h08;
            EK_PABT:  return 8'h0C;
            EK_DABT:  return 8'h10;
            EK_IRQ:   return 8'h18;
            EK_FIQ:   return 8'h1C;
            default:  return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic      rq_reset,
    input  logic      rq_dabort,
    input  logic      rq_fiq,
    input  logic      rq_irq,
    input  logic      rq_pabort,
    input  logic      rq_undef,
    input  logic      rq_swi,
    input  logic      irq_masked,
    input  logic      fiq_masked,
    output logic      win_valid,
    output exc_kind_e win_kind
);

    logic [NUM_KINDS-1:0] pend;

    // Pending vector, indexed by priority rank (R6, R7).
    always_comb begin
        pend            = '0;
        pend[EK_RESET]  = rq_reset;
        pend[EK_DABT]   = rq_dabort;
        pend[EK_FIQ]    = rq_fiq & ~fiq_masked;
        pend[EK_IRQ]    = rq_irq & ~irq_masked;
        pend[EK_PABT]   = rq_pabort;
        pend[EK_UNDEF]  = rq_undef;
        pend[EK_SWI]    = rq_swi;
    end

    // Scan from lowest to highest priority; the last hit wins.
    always_comb begin
        win_valid = |pend;
        win_kind  = EK_SWI;
        for (int i = NUM_KINDS - 1; i >= 0; i--) begin
            if (pend[i]) win_kind = exc_kind_e'(i[KIND_W-1:0]);
        end
    end

endmodule

// File: rtl/exc_psr_build.sv
module exc_psr_build
    import exc_pkg::*;
#(
    parameter int             PSR_W    = 32,
    parameter int             PC_W     = 32,
    parameter logic [PC_W-1:0] VEC_BASE = '0
) (
    input  exc_kind_e         kind,
    input  logic [PSR_W-1:0]  old_psr,
    output logic [PSR_W-1:0]  new_psr,
    output logic [MODE_W-1:0] new_mode,
    output logic [PC_W-1:0]   vector
);

    always_comb begin
        new_mode               = kind_mode(kind);
        vector                 = VEC_BASE + PC_W'(kind_vec_off(kind));
        new_psr                = old_psr;
        new_psr[MODE_W-1:0]    = new_mode;
        new_psr[BIT_T]         = 1'b0;
        new_psr[BIT_I]         = 1'b1;
        if (kind == EK_FIQ || kind == EK_RESET) new_psr[BIT_F] = 1'b1;
    end

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
#(
    parameter int             PSR_W    = 32,
    parameter int             PC_W     = 32,
    parameter logic [PC_W-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rq_reset,
    input  logic              rq_dabort,
    input  logic              rq_fiq,
    input  logic              rq_irq,
    input  logic              rq_pabort,
    input  logic              rq_undef,
    input  logic              rq_swi,
    input  logic              rq_return,
    input  logic [PSR_W-1:0]  cur_psr,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [PSR_W-1:0]  saved_psr,
    input  logic [PC_W-1:0]   resume_pc,
    output logic              psr_we,
    output logic [PSR_W-1:0]  psr_wdata,
    output logic              pc_we,
    output logic [PC_W-1:0]   pc_wdata,
    output logic              lr_we,
    output logic              spsr_we,
    output logic [MODE_W-1:0] bank_mode,
    output logic [PC_W-1:0]   lr_wdata,
    output logic [PSR_W-1:0]  spsr_wdata
);

    ctl_state_e        state;
    exc_kind_e         kind_q;
    logic [PSR_W-1:0]  psr_q;
    logic [PC_W-1:0]   pc_q;

    logic              win_valid;
    exc_kind_e         win_kind;
    logic [PSR_W-1:0]  entry_psr;
    logic [MODE_W-1:0] entry_mode;
    logic [PC_W-1:0]   entry_vec;

    exc_arbiter arb_i (
        .rq_reset   (rq_reset),
        .rq_dabort  (rq_dabort),
        .rq_fiq     (rq_fiq),
        .rq_irq     (rq_irq),
        .rq_pabort  (rq_pabort),
        .rq_undef   (rq_undef),
        .rq_swi     (rq_swi),
        .irq_masked (cur_psr[BIT_I]),
        .fiq_masked (cur_psr[BIT_F]),
        .win_valid  (win_valid),
        .win_kind   (win_kind)
    );

    exc_psr_build #(
        .PSR_W    (PSR_W),
        .PC_W     (PC_W),
        .VEC_BASE (VEC_BASE)
    ) build_i (
        .kind     (kind_q),
        .old_psr  (psr_q),
        .new_psr  (entry_psr),
        .new_mode (entry_mode),
        .vector   (entry_vec)
    );

    // State register and captured operands.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind_q <= EK_RESET;
            psr_q  <= '0;
            pc_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (win_valid) begin            // R9: exception beats return
                        state  <= ST_ENTER;
                        kind_q <= win_kind;
                        psr_q  <= cur_psr;
                        pc_q   <= cur_pc;
                    end else if (rq_return) begin
                        state  <= ST_RETURN;
                        psr_q  <= saved_psr;
                        pc_q   <= resume_pc;
                    end
                end
                ST_ENTER:  state <= ST_IDLE;
                ST_RETURN: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        psr_we     = 1'b0;
        pc_we      = 1'b0;
        lr_we      = 1'b0;
        spsr_we    = 1'b0;
        psr_wdata  = '0;
        pc_wdata   = '0;
        lr_wdata   = '0;
        spsr_wdata = '0;
        bank_mode  = '0;
        unique case (state)
            ST_IDLE: ;
            ST_ENTER: begin
                psr_we     = 1'b1;
                pc_we      = 1'b1;
                lr_we      = 1'b1;
                spsr_we    = 1'b1;
                psr_wdata  = entry_psr;
                pc_wdata   = entry_vec;
                lr_wdata   = pc_q;
                spsr_wdata = psr_q;
                bank_mode  = entry_mode;
            end
            ST_RETURN: begin
                psr_we     = 1'b1;
                pc_we      = 1'b1;
                psr_wdata  = psr_q;
                pc_wdata   = pc_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk
    import exc_pkg::*;
#(
    parameter int             PC_W     = 32,
    parameter logic [PC_W-1:0] VEC_BASE = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_mask,
    input logic              fiq_mask,
    input logic              psr_we,
    input logic              pc_we,
    input logic              lr_we,
    input logic              spsr_we,
    input logic [MODE_W-1:0] bank_mode,
    input logic [7:0]        psr_low,
    input logic [PC_W-1:0]   pc_wdata
);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_quiet_in_reset_R1: assert (!psr_we && !pc_we && !lr_we && !spsr_we)
                else $error("strobe active during reset");
        end
    end

    assert_entry_strobes_together_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |-> (psr_we && pc_we && spsr_we));

    assert_entry_status_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |-> (psr_low[BIT_I] && !psr_low[BIT_T] && psr_low[MODE_W-1:0] == bank_mode));

    assert_fiq_sets_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_we && bank_mode == MODE_FAST) |-> psr_low[BIT_F]);

    assert_fiq_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_we && bank_mode == MODE_FAST) |-> pc_wdata == VEC_BASE + PC_W'(8'h1C));

    assert_irq_only_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_we && bank_mode == MODE_NORM) |-> !$past(irq_mask));

    assert_fiq_only_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_we && bank_mode == MODE_FAST) |-> !$past(fiq_mask));

    assert_return_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (psr_we && !lr_we) |-> (pc_we && !spsr_we));

    assert_gap_after_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        psr_we |=> !psr_we);

endmodule

bind exc_ctrl exc_ctrl_chk #(
    .PC_W     (PC_W),
    .VEC_BASE (VEC_BASE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_mask  (cur_psr[7]),
    .fiq_mask  (cur_psr[6]),
    .psr_we    (psr_we),
    .pc_we     (pc_we),
    .lr_we     (lr_we),
    .spsr_we   (spsr_we),
    .bank_mode (bank_mode),
    .psr_low   (psr_wdata[7:0]),
    .pc_wdata  (pc_wdata)
);

// File: tb/exc_ctrl_tb_top.sv
module exc_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rq_reset = 0, rq_dabort = 0, rq_fiq = 0, rq_irq = 0;
    logic        rq_pabort = 0, rq_undef = 0, rq_swi = 0, rq_return = 0;
    logic [31:0] cur_psr = 32'h10, cur_pc = '0, saved_psr = '0, resume_pc = '0;
    logic        psr_we, pc_we, lr_we, spsr_we;
    logic [31:0] psr_wdata, pc_wdata, lr_wdata, spsr_wdata;
    logic [4:0]  bank_mode;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    exc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .rq_reset(rq_reset), .rq_dabort(rq_dabort), .rq_fiq(rq_fiq), .rq_irq(rq_irq),
        .rq_pabort(rq_pabort), .rq_undef(rq_undef), .rq_swi(rq_swi), .rq_return(rq_return),
        .cur_psr(cur_psr), .cur_pc(cur_pc), .saved_psr(saved_psr), .resume_pc(resume_pc),
        .psr_we(psr_we), .psr_wdata(psr_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata),
        .lr_we(lr_we), .spsr_we(spsr_we), .bank_mode(bank_mode),
        .lr_wdata(lr_wdata), .spsr_wdata(spsr_wdata)
    );

    // rq bits: [7] return [6] reset [5] dabort [4] fiq [3] irq [2] pabort [1] undef [0] swi
    typedef struct packed {
        logic [7:0]  rq;
        logic [31:0] psr;
        logic        ent;
        logic [4:0]  mode;
        logic [7:0]  vec;
        logic        fset;
    } tv_t;

    localparam int NV = 20;
    localparam tv_t TV [NV] = '{
        '{8'b0100_0000, 32'h0000_0030, 1'b1, 5'h13, 8'h00, 1'b1},
        '{8'b0010_0000, 32'h0000_0030, 1'b1, 5'h17, 8'h10, 1'b0},
        '{8'b0001_0000, 32'h8000_0010, 1'b1, 5'h11, 8'h1C, 1'b1},
        '{8'b0000_1000, 32'h4000_0010, 1'b1, 5'h12, 8'h18, 1'b0},
        '{8'b0000_0100, 32'h0000_0010, 1'b1, 5'h17, 8'h0C, 1'b0},
        '{8'b0000_0010, 32'h0000_0030, 1'b1, 5'h1B, 8'h04, 1'b0},
        '{8'b0000_0001, 32'h0000_0010, 1'b1, 5'h13, 8'h08, 1'b0},
        '{8'b0111_1111, 32'h0000_0010, 1'b1, 5'h13, 8'h00, 1'b1},
        '{8'b0011_1000, 32'h0000_0010, 1'b1, 5'h17, 8'h10, 1'b0},
        '{8'b0001_1100, 32'h0000_0010, 1'b1, 5'h11, 8'h1C, 1'b1},
        '{8'b0000_1110, 32'h0000_0010, 1'b1, 5'h12, 8'h18, 1'b0},
        '{8'b0000_0111, 32'h0000_0010, 1'b1, 5'h17, 8'h0C, 1'b0},
        '{8'b0000_0011, 32'h0000_0010, 1'b1, 5'h1B, 8'h04, 1'b0},
        '{8'b0000_1000, 32'h0000_0090, 1'b0, 5'h00, 8'h00, 1'b0},
        '{8'b0001_0000, 32'h0000_0050, 1'b0, 5'h00, 8'h00, 1'b0},
        '{8'b0001_1000, 32'h0000_0050, 1'b1, 5'h12, 8'h18, 1'b0},
        '{8'b0001_1100, 32'h0000_00D0, 1'b1, 5'h17, 8'h0C, 1'b0},
        '{8'b1000_1000, 32'h0000_0010, 1'b1, 5'h12, 8'h18, 1'b0},
        '{8'b0000_0001, 32'hF000_00F0, 1'b1, 5'h13, 8'h08, 1'b0},
        '{8'b0100_0000, 32'h0000_00D3, 1'b1, 5'h13, 8'h00, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive_rq(input logic [7:0] r);
        {rq_return, rq_reset, rq_dabort, rq_fiq, rq_irq, rq_pabort, rq_undef, rq_swi} = r;
    endtask

    task automatic chk_quiet(input string req);
        chk(req, "strobes", {28'd0, psr_we, pc_we, lr_we, spsr_we}, 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, with requests active during reset
        drive_rq(8'b0111_1111);
        repeat (3) @(negedge clk);
        chk_quiet("R1 in reset");
        drive_rq(8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_quiet("R1 idle");

        // Vector table: R2 R3 R4 R5 R6 R7 R9
        for (int k = 0; k < NV; k++) begin
            logic [31:0] exp_psr;
            @(negedge clk);
            drive_rq(TV[k].rq);
            cur_psr   = TV[k].psr;
            cur_pc    = 32'h0000_4000 + 32'(k) * 16;
            saved_psr = 32'h6000_001F;
            resume_pc = 32'h0000_8888;
            @(negedge clk);
            drive_rq(8'h00);
            cur_psr = 32'h0;
            cur_pc  = 32'hDEAD_0000;
            if (TV[k].ent) begin
                exp_psr = {TV[k].psr[31:8], 1'b1, TV[k].fset | TV[k].psr[6], 1'b0, TV[k].mode};
                chk("R2 R9", "strobes", {28'd0, psr_we, pc_we, lr_we, spsr_we}, 32'hF);
                chk("R2 R6", "bank_mode", {27'd0, bank_mode}, {27'd0, TV[k].mode});
                chk("R3", "lr_wdata", lr_wdata, 32'h0000_4000 + 32'(k) * 16);
                chk("R3", "spsr_wdata", spsr_wdata, TV[k].psr);
                chk("R4 R7", "psr_wdata", psr_wdata, exp_psr);
                chk("R5 R6", "pc_wdata", pc_wdata, {24'd0, TV[k].vec});
            end else begin
                chk_quiet("R7 masked");
            end
            @(negedge clk);
            chk_quiet("R10 gap");
        end

        // R8: atomic return
        @(negedge clk);
        cur_psr   = 32'h0000_00D2;
        saved_psr = 32'h2000_0010;
        resume_pc = 32'h0000_1234;
        rq_return = 1'b1;
        @(negedge clk);
        rq_return = 1'b0;
        chk("R8", "strobes", {28'd0, psr_we, pc_we, lr_we, spsr_we}, 32'hC);
        chk("R8", "psr_wdata", psr_wdata, 32'h2000_0010);
        chk("R8", "pc_wdata", pc_wdata, 32'h0000_1234);
        @(negedge clk);
        chk_quiet("R10 after return");

        // R7 R10: held level IRQ is taken once, then masked by the written status
        @(negedge clk);
        cur_psr = 32'h0000_0010;
        rq_irq  = 1'b1;
        @(negedge clk);
        chk("R7", "irq entry lr_we", {31'd0, lr_we}, 32'd1);
        cur_psr = psr_wdata;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk_quiet("R7 R10 held irq");
        end
        rq_irq = 1'b0;

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule